// File: doc/BRIEF.md
# ATA Channel Command Decoder

This block holds the command-side state of one ATA/ATAPI channel that serves two drive slots. Single-byte writes to the command register are decoded against a small packet-oriented command set. Each accepted command updates the status and error registers, can arm a twelve-byte command-packet collection, and can raise the channel interrupt. The device-control register's interrupt-disable bit gates the interrupt. A sticky bus-master interrupt flag records every interrupt that is actually delivered.

The data port is a byte stream into a per-slot packet buffer. Every accepted byte advances a channel-wide transfer index. When the index reaches the armed length under the packet command, the collected bytes go out on a valid/ready packet interface to a downstream packet handler. The command and task-file register ports are plain one-cycle write strobes.

Stream rules:
- A data byte is taken on any cycle where `dp_valid` and `dp_ready` are both high.
- `dp_ready` is low while a packet is waiting for the handler, and also on any cycle that carries a command write.
- Once `pkt_valid` rises, it and `pkt_data` stay unchanged until the handler answers with `pkt_ready`.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: A command write whose `cmd_len` is not 1 is refused. `bad_len` pulses for one cycle, and the command, status and error registers keep their values.
- R2: Command 0xA0 sent to a slot of kind optical (`slot_kind` code 2'b01) does the following: sets the sector count to 1, clears status bits 7, 5 and 0, sets status bit 3, arms a transfer length of 12, zeroes the transfer index, leaves the error register alone and raises no interrupt.
- R3: Command 0xA0 sent to a slot of any other kind (2'b00 disk, 2'b10 empty) first runs the abort: status 0x41, error 0x04, interrupt raised. The packet setup of R2 then applies to that status, so status ends at 0x48.
- R4: Command 0xA1 sets status to 0x58, clears the error register, pulses `ident_load` and raises the interrupt.
- R5: Command 0xEF clears status bits 7, 5 and 0, sets bits 6 and 4, and raises the interrupt.
- R6: Any other command value is stored in the command register. It pulses `bad_cmd` and leaves status and error unchanged.
- R7: A raised interrupt gives an `irq` pulse and sets `bm_int` only when device-control bit 1 is 0. `bm_int` stays set until `bm_int_clr`.
- R8: Each accepted data byte is stored at the current index of the selected slot's buffer, and the index then increments. `pkt_data` byte k sits at bits [8k+7:8k]. When the incremented index reaches the transfer length and the command register holds 0xA0, `pkt_valid` is raised and held until `pkt_ready`.
- R9: When the incremented index reaches the transfer length while the command register holds any value other than 0xA0, `bad_dispatch` pulses and no packet is offered.
- R10: After reset: sector count 0x01, sector number 0x01, cylinder 0x0000, error 0x01, command 0x00, status 0x00, transfer index 0, and no interrupt.
- R11: Bit 4 of the drive/head register selects the slot. That slot supplies the drive kind used by R2/R3 and the buffer that receives bytes and drives `pkt_data`.
- R12: Task-file writes store their byte in a register chosen by `tf_sel`: 0 sector count, 1 sector number, 2 cylinder low, 3 cylinder high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| slot_kind | input | 4 | Kind of slot 0 in [1:0] and slot 1 in [3:2] (00 disk, 01 optical, 10 empty) |
| tf_wr | input | 1 | Task-file register write strobe |
| tf_sel | input | 2 | Task-file register select |
| tf_wdata | input | 8 | Task-file write byte |
| dh_wr | input | 1 | Drive/head register write strobe |
| dh_wdata | input | 8 | Drive/head write byte |
| dc_wr | input | 1 | Device-control register write strobe |
| dc_wdata | input | 8 | Device-control write byte |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_len | input | 3 | Byte width of the command write |
| cmd_wdata | input | 8 | Command byte |
| dp_valid | input | 1 | Data byte valid |
| dp_ready | output | 1 | Data byte can be taken |
| dp_data | input | 8 | Data byte |
| pkt_valid | output | 1 | Collected packet offered |
| pkt_ready | input | 1 | Handler takes the packet |
| pkt_data | output | 96 | Packet bytes of the selected slot |
| bm_int_clr | input | 1 | Clears the bus-master interrupt flag |
| irq | output | 1 | One-cycle interrupt pulse |
| bm_int | output | 1 | Sticky bus-master interrupt flag |
| status | output | 8 | Status register |
| error | output | 8 | Error register |
| sect_cnt | output | 8 | Sector count register |
| sect_num | output | 8 | Sector number register |
| cylinder | output | 16 | Cylinder high and low registers |
| drive_head | output | 8 | Drive/head register |
| cmd_reg | output | 8 | Last accepted command byte |
| xfer_idx | output | 5 | Transfer index |
| xfer_len | output | 5 | Armed transfer length |
| ident_load | output | 1 | Pulse asking for identify data to be loaded |
| bad_len | output | 1 | Pulse: command write of wrong width |
| bad_cmd | output | 1 | Pulse: unsupported command |
| bad_dispatch | output | 1 | Pulse: transfer completed under a non-packet command |

## Verification
The assertions assume that at most one register write strobe is active in any cycle. They also assume that device-control is not rewritten in the same cycle as a command write, so the gating value checked for an interrupt is the one held when the command was decoded. The stimulus drives every register access as a single isolated strobe between falling edges. It offers data bytes only while `dp_ready` is high and no command write is pending. It raises `pkt_ready` only after it has observed a held packet.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  typedef enum logic [1:0] {
    KIND_DISK    = 2'd0,
    KIND_OPTICAL = 2'd1,
    KIND_EMPTY   = 2'd2
  } dev_kind_e;

  localparam logic [7:0] OP_PACKET    = 8'hA0;
  localparam logic [7:0] OP_PKT_IDENT = 8'hA1;
  localparam logic [7:0] OP_SET_FEAT  = 8'hEF;

  localparam logic [7:0] ST_BSY = 8'h80;
  localparam logic [7:0] ST_RDY = 8'h40;
  localparam logic [7:0] ST_DF  = 8'h20;
  localparam logic [7:0] ST_DSC = 8'h10;
  localparam logic [7:0] ST_DRQ = 8'h08;
  localparam logic [7:0] ST_ERR = 8'h01;

  localparam logic [7:0] ABORT_STATUS = 8'h41;
  localparam logic [7:0] ABORT_ERROR  = 8'h04;
  localparam logic [7:0] IDENT_STATUS = 8'h58;

  typedef struct packed {
    logic [7:0] status;
    logic       load_err;
    logic [7:0] err;
    logic       irq;
    logic       pkt_setup;
    logic       ident;
    logic       unsup;
  } cmd_act_t;
endpackage

// File: rtl/ata_cmd_decode.sv
module ata_cmd_decode
  import ata_tf_pkg::*;
(
  input  logic [7:0] op,
  input  dev_kind_e  kind,
  input  logic [7:0] status_cur,
  output cmd_act_t   act
);
  logic [7:0] st;

  always_comb begin
    act        = '0;
    act.status = status_cur;
    st         = status_cur;
    case (op)
      OP_PACKET: begin
        if (kind != KIND_OPTICAL) begin
          st           = ABORT_STATUS;
          act.load_err = 1'b1;
          act.err      = ABORT_ERROR;
          act.irq      = 1'b1;
        end
        act.status    = (st & ~(ST_BSY | ST_DF | ST_ERR)) | ST_DRQ;
        act.pkt_setup = 1'b1;
      end
      OP_PKT_IDENT: begin
        act.status   = IDENT_STATUS;
        act.load_err = 1'b1;
        act.err      = 8'h00;
        act.irq      = 1'b1;
        act.ident    = 1'b1;
      end
      OP_SET_FEAT: begin
        act.status = (status_cur & ~(ST_BSY | ST_DF | ST_ERR)) | ST_RDY | ST_DSC;
        act.irq    = 1'b1;
      end
      default: act.unsup = 1'b1;
    endcase
  end
endmodule

// File: rtl/ata_pkt_slot.sv
module ata_pkt_slot #(
  parameter int BUF_BYTES = 16,
  parameter int PKT_BYTES = 12,
  localparam int IDXW = $clog2(BUF_BYTES + 1),
  localparam int AW   = $clog2(BUF_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDXW-1:0]        wr_idx,
  input  logic [7:0]             wr_byte,
  output logic [PKT_BYTES*8-1:0] pkt_bytes
);
  logic [7:0] mem [BUF_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BUF_BYTES; i++) mem[i] <= 8'h00;
    end else if (wr_en && (wr_idx < IDXW'(BUF_BYTES))) begin
      mem[wr_idx[AW-1:0]] <= wr_byte;
    end
  end

  for (genvar g = 0; g < PKT_BYTES; g++) begin : g_out
    assign pkt_bytes[g*8 +: 8] = mem[g];
  end
endmodule

// File: rtl/ata_irq_ctl.sv
module ata_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic raise_i,
  input  logic dis_i,
  input  logic bm_clr_i,
  output logic irq_o,
  output logic bm_int_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o    <= 1'b0;
      bm_int_o <= 1'b0;
    end else begin
      irq_o <= raise_i && !dis_i;
      if (raise_i && !dis_i) bm_int_o <= 1'b1;
      else if (bm_clr_i)     bm_int_o <= 1'b0;
    end
  end

  // R7: an interrupt pulse only follows a cycle with gating open
  a_r7_gate_open: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !$past(dis_i));
  // R7: a delivered interrupt always leaves the bus-master flag set
  a_r7_bm_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> bm_int_o);
  // R7: with gating closed no new interrupt appears
  a_r7_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_i && dis_i) |=> !irq_o);
endmodule

// File: rtl/ata_taskfile_ctrl.sv
module ata_taskfile_ctrl
  import ata_tf_pkg::*;
#(
  parameter int BUF_BYTES = 16,
  parameter int PKT_BYTES = 12,
  localparam int NSLOT = 2,
  localparam int IDXW  = $clog2(BUF_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2*NSLOT-1:0]     slot_kind,
  input  logic                   tf_wr,
  input  logic [1:0]             tf_sel,
  input  logic [7:0]             tf_wdata,
  input  logic                   dh_wr,
  input  logic [7:0]             dh_wdata,
  input  logic                   dc_wr,
  input  logic [7:0]             dc_wdata,
  input  logic                   cmd_wr,
  input  logic [2:0]             cmd_len,
  input  logic [7:0]             cmd_wdata,
  input  logic                   dp_valid,
  output logic                   dp_ready,
  input  logic [7:0]             dp_data,
  output logic                   pkt_valid,
  input  logic                   pkt_ready,
  output logic [PKT_BYTES*8-1:0] pkt_data,
  input  logic                   bm_int_clr,
  output logic                   irq,
  output logic                   bm_int,
  output logic [7:0]             status,
  output logic [7:0]             error,
  output logic [7:0]             sect_cnt,
  output logic [7:0]             sect_num,
  output logic [15:0]            cylinder,
  output logic [7:0]             drive_head,
  output logic [7:0]             cmd_reg,
  output logic [IDXW-1:0]        xfer_idx,
  output logic [IDXW-1:0]        xfer_len,
  output logic                   ident_load,
  output logic                   bad_len,
  output logic                   bad_cmd,
  output logic                   bad_dispatch
);
  localparam int SEL_BIT = 4;
  localparam int DIS_BIT = 1;

  logic [7:0]      devctl;
  logic            sel;
  dev_kind_e       cur_kind;
  cmd_act_t        act;
  logic            cmd_go;
  logic            dp_fire;
  logic [IDXW-1:0] idx_inc;
  logic [PKT_BYTES*8-1:0] slot_bytes [NSLOT];

  assign sel      = drive_head[SEL_BIT];
  assign cur_kind = dev_kind_e'(slot_kind[sel*2 +: 2]);
  assign cmd_go   = cmd_wr && (cmd_len == 3'd1);
  assign dp_ready = !pkt_valid && !cmd_wr;
  assign dp_fire  = dp_valid && dp_ready;
  assign idx_inc  = (xfer_idx == IDXW'(BUF_BYTES)) ? xfer_idx : xfer_idx + 1'b1;

  ata_cmd_decode u_dec (
    .op         (cmd_wdata),
    .kind       (cur_kind),
    .status_cur (status),
    .act        (act)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    ata_pkt_slot #(.BUF_BYTES(BUF_BYTES), .PKT_BYTES(PKT_BYTES)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (dp_fire && (sel == 1'(g))),
      .wr_idx    (xfer_idx),
      .wr_byte   (dp_data),
      .pkt_bytes (slot_bytes[g])
    );
  end

  assign pkt_data = slot_bytes[sel];

  ata_irq_ctl u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .raise_i  (cmd_go && act.irq),
    .dis_i    (devctl[DIS_BIT]),
    .bm_clr_i (bm_int_clr),
    .irq_o    (irq),
    .bm_int_o (bm_int)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status       <= 8'h00;
      error        <= 8'h01;
      sect_cnt     <= 8'h01;
      sect_num     <= 8'h01;
      cylinder     <= 16'h0000;
      drive_head   <= 8'h00;
      devctl       <= 8'h08;
      cmd_reg      <= 8'h00;
      xfer_idx     <= '0;
      xfer_len     <= '0;
      pkt_valid    <= 1'b0;
      ident_load   <= 1'b0;
      bad_len      <= 1'b0;
      bad_cmd      <= 1'b0;
      bad_dispatch <= 1'b0;
    end else begin
      ident_load   <= 1'b0;
      bad_cmd      <= 1'b0;
      bad_dispatch <= 1'b0;
      bad_len      <= cmd_wr && !cmd_go;

      if (tf_wr) begin
        case (tf_sel)
          2'd0: sect_cnt        <= tf_wdata;
          2'd1: sect_num        <= tf_wdata;
          2'd2: cylinder[7:0]   <= tf_wdata;
          2'd3: cylinder[15:8]  <= tf_wdata;
          default: ;
        endcase
      end
      if (dh_wr) drive_head <= dh_wdata;
      if (dc_wr) devctl     <= dc_wdata;

      if (pkt_valid && pkt_ready) pkt_valid <= 1'b0;

      if (cmd_go) begin
        cmd_reg    <= cmd_wdata;
        status     <= act.status;
        bad_cmd    <= act.unsup;
        ident_load <= act.ident;
        if (act.load_err) error <= act.err;
        if (act.pkt_setup) begin
          sect_cnt  <= 8'h01;
          xfer_len  <= IDXW'(PKT_BYTES);
          xfer_idx  <= '0;
          pkt_valid <= 1'b0;
        end
      end else if (dp_fire) begin
        xfer_idx <= idx_inc;
        if (idx_inc >= xfer_len) begin
          if (cmd_reg == OP_PACKET) pkt_valid    <= 1'b1;
          else                      bad_dispatch <= 1'b1;
        end
      end
    end
  end

  // R1: a wrongly sized command write changes nothing it guards
  a_r1_len_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_len != 3'd1) |=> (bad_len && $stable(status) && $stable(cmd_reg) && $stable(error)));
  // R4: identify settles status and error
  a_r4_ident_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && cmd_wdata == OP_PKT_IDENT) |=> (status == IDENT_STATUS && error == 8'h00));
  // R6: unsupported command leaves status in place
  a_r6_unsup_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && cmd_wdata != OP_PACKET && cmd_wdata != OP_PKT_IDENT && cmd_wdata != OP_SET_FEAT)
      |=> (bad_cmd && $stable(status)));
  // R8: an offered packet holds until taken
  a_r8_pkt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready && !cmd_wr) |=> (pkt_valid && $stable(pkt_data)));
  // R8: the index never runs past the buffer
  a_r8_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_idx <= IDXW'(BUF_BYTES));
endmodule

// File: tb/test_ata_taskfile_ctrl.sv
module test_ata_taskfile_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  slot_kind = 4'b0001;
  logic        tf_wr = 0, dh_wr = 0, dc_wr = 0, cmd_wr = 0;
  logic [1:0]  tf_sel = 0;
  logic [7:0]  tf_wdata = 0, dh_wdata = 0, dc_wdata = 0, cmd_wdata = 0;
  logic [2:0]  cmd_len = 3'd1;
  logic        dp_valid = 0, pkt_ready = 0, bm_int_clr = 0;
  logic [7:0]  dp_data = 0;
  logic        dp_ready, pkt_valid, irq, bm_int, ident_load, bad_len, bad_cmd, bad_dispatch;
  logic [95:0] pkt_data;
  logic [7:0]  status, error, sect_cnt, sect_num, drive_head, cmd_reg;
  logic [15:0] cylinder;
  logic [4:0]  xfer_idx, xfer_len;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct { string req; int kind; logic [15:0] exp; } item_t;
  item_t q[$];
  event chk_ev;

  always #10 clk = ~clk;

  ata_taskfile_ctrl i_ata_taskfile_ctrl (
    .clk, .rst_n, .slot_kind, .tf_wr, .tf_sel, .tf_wdata, .dh_wr, .dh_wdata,
    .dc_wr, .dc_wdata, .cmd_wr, .cmd_len, .cmd_wdata, .dp_valid, .dp_ready,
    .dp_data, .pkt_valid, .pkt_ready, .pkt_data, .bm_int_clr, .irq, .bm_int,
    .status, .error, .sect_cnt, .sect_num, .cylinder, .drive_head, .cmd_reg,
    .xfer_idx, .xfer_len, .ident_load, .bad_len, .bad_cmd, .bad_dispatch
  );

  function automatic logic [15:0] observe(int kind);
    case (kind)
      0: return {8'h0, status};
      1: return {8'h0, error};
      2: return {8'h0, sect_cnt};
      3: return {8'h0, sect_num};
      4: return cylinder;
      5: return {8'h0, cmd_reg};
      6: return {11'h0, xfer_idx};
      7: return {11'h0, xfer_len};
      8: return {15'h0, irq};
      9: return {15'h0, bm_int};
      10: return {15'h0, bad_len};
      11: return {15'h0, bad_cmd};
      12: return {15'h0, bad_dispatch};
      13: return {15'h0, pkt_valid};
      14: return {15'h0, ident_load};
      15: return {15'h0, dp_ready};
      default: return {8'h0, pkt_data[(kind-20)*8 +: 8]};
    endcase
  endfunction

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] got;
        it = q.pop_front();
        got = observe(it.kind);
        total++;
        if (got !== it.exp) begin
          bad++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, got, it.exp);
        end
      end
    end
  end

  task automatic expect_val(string req, int kind, logic [15:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic flush();
    -> chk_ev;
    #1;
  endtask

  task automatic wr_cmd(logic [2:0] len, logic [7:0] op);
    @(negedge clk); cmd_wr = 1; cmd_len = len; cmd_wdata = op;
    @(negedge clk); cmd_wr = 0; cmd_len = 3'd1;
  endtask

  task automatic wr_tf(logic [1:0] s, logic [7:0] d);
    @(negedge clk); tf_wr = 1; tf_sel = s; tf_wdata = d;
    @(negedge clk); tf_wr = 0;
  endtask

  task automatic wr_dh(logic [7:0] d);
    @(negedge clk); dh_wr = 1; dh_wdata = d;
    @(negedge clk); dh_wr = 0;
  endtask

  task automatic wr_dc(logic [7:0] d);
    @(negedge clk); dc_wr = 1; dc_wdata = d;
    @(negedge clk); dc_wr = 0;
  endtask

  task automatic send_byte(logic [7:0] b);
    @(negedge clk); dp_valid = 1; dp_data = b;
    @(negedge clk); dp_valid = 0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset values
    expect_val("R10", 0, 16'h00); expect_val("R10", 1, 16'h01);
    expect_val("R10", 2, 16'h01); expect_val("R10", 3, 16'h01);
    expect_val("R10", 4, 16'h0000); expect_val("R10", 5, 16'h00);
    expect_val("R10", 6, 16'h0); expect_val("R10", 8, 16'h0);
    expect_val("R10", 9, 16'h0);
    flush();

    // R12 task-file stores
    wr_tf(2'd0, 8'h22); wr_tf(2'd1, 8'h33); wr_tf(2'd2, 8'h44); wr_tf(2'd3, 8'h55);
    expect_val("R12", 2, 16'h22); expect_val("R12", 3, 16'h33);
    expect_val("R12", 4, 16'h5544);
    flush();

    // R1 wrong width
    wr_cmd(3'd2, 8'hA1);
    expect_val("R1", 10, 16'h1); expect_val("R1", 5, 16'h00);
    expect_val("R1", 0, 16'h00); expect_val("R1", 1, 16'h01);
    flush();

    // R5 set features, R7 interrupt and flag
    wr_cmd(3'd1, 8'hEF);
    expect_val("R5", 0, 16'h50); expect_val("R7", 8, 16'h1); expect_val("R7", 9, 16'h1);
    flush();
    @(negedge clk); bm_int_clr = 1;
    @(negedge clk); bm_int_clr = 0;
    expect_val("R7", 9, 16'h0);
    flush();

    // R4 identify
    wr_cmd(3'd1, 8'hA1);
    expect_val("R4", 0, 16'h58); expect_val("R4", 1, 16'h00);
    expect_val("R4", 14, 16'h1); expect_val("R4", 8, 16'h1);
    flush();

    // R6 unsupported
    wr_cmd(3'd1, 8'h55);
    expect_val("R6", 11, 16'h1); expect_val("R6", 0, 16'h58); expect_val("R6", 5, 16'h55);
    expect_val("R6", 1, 16'h00);
    flush();

    // R7 gating closed
    wr_dc(8'h02);
    @(negedge clk); bm_int_clr = 1;
    @(negedge clk); bm_int_clr = 0;
    wr_cmd(3'd1, 8'hEF);
    expect_val("R7", 8, 16'h0); expect_val("R7", 9, 16'h0); expect_val("R5", 0, 16'h58);
    flush();
    wr_dc(8'h00);

    // R2 packet command on optical slot 0
    wr_cmd(3'd1, 8'hA0);
    expect_val("R2", 0, 16'h58); expect_val("R2", 1, 16'h00); expect_val("R2", 2, 16'h01);
    expect_val("R2", 7, 16'd12); expect_val("R2", 6, 16'd0); expect_val("R2", 8, 16'h0);
    flush();

    // R8 packet collection
    for (int k = 0; k < 11; k++) send_byte(8'h10 + 8'(k));
    expect_val("R8", 6, 16'd11); expect_val("R8", 13, 16'h0);
    flush();
    send_byte(8'h1B);
    expect_val("R8", 13, 16'h1); expect_val("R8", 15, 16'h0);
    expect_val("R8", 20, 16'h10); expect_val("R8", 31, 16'h1B);
    flush();
    @(negedge clk);
    expect_val("R8", 13, 16'h1);
    flush();
    pkt_ready = 1;
    @(negedge clk); pkt_ready = 0;
    expect_val("R8", 13, 16'h0); expect_val("R8", 15, 16'h1);
    flush();

    // R11 select slot 1 (disk), R3 abort path
    wr_dh(8'h10);
    wr_cmd(3'd1, 8'hA0);
    expect_val("R3", 0, 16'h48); expect_val("R3", 1, 16'h04); expect_val("R3", 8, 16'h1);
    expect_val("R3", 7, 16'd12);
    flush();

    // R9 completion under a non-packet command
    wr_cmd(3'd1, 8'hEF);
    for (int k = 0; k < 11; k++) send_byte(8'hA0 + 8'(k));
    expect_val("R9", 12, 16'h0);
    flush();
    send_byte(8'hAB);
    expect_val("R9", 12, 16'h1); expect_val("R9", 13, 16'h0);
    expect_val("R11", 20, 16'hA0);
    flush();

    // R11 slot 0 buffer kept separately
    wr_dh(8'h00);
    expect_val("R11", 20, 16'h10); expect_val("R11", 31, 16'h1B);
    flush();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule